// File: doc/BRIEF.md
# Address-space-tagged fully associative translation buffer

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a virtual page number tag, an address space number, a global flag, a physical frame number, per-mode read and write enable masks, a fault-on-read bit, a fault-on-write bit and a valid bit. A combinational lookup port compares a requested page number and the current address space number against every slot at once. It returns the matching slot's index and its translation fields. Permission checking, fault reporting and page table walks are left to the logic around the block.

Every change to the array goes through a single operation code, so only one operation is accepted per cycle. An insert writes the slot chosen by a rotating next-to-use pointer. It replaces whatever that slot held and then moves the pointer on by one. Three invalidation operations are provided: clear the whole array, drop every entry that is not global, or drop the entries that match one page number and address space number.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits a slot only when the slot is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address space number equals `lk_asn`. A slot whose global flag is clear and whose stored number differs from `lk_asn` never hits.
- R2: Operation code 1 (insert) writes the slot selected by the next-to-use pointer, even if that slot is valid, and then advances the pointer by one.
- R3: An inserted slot becomes valid, and its tag is bits VA_W-1 down to PAGE_BITS of `op_vaddr`. The low offset bits are ignored. Its frame number, read mask, write mask, fault bits, global flag and address space number are taken from the `op_*` inputs and reported on `lk_*` when the slot hits.
- R4: After reset, and after operation code 2 (flush all), no lookup hits, and the next insert goes to slot 0.
- R5: Operation code 3 (flush process) invalidates every slot whose global flag is clear and leaves global slots hitting as before.
- R6: Operation code 4 (flush address) invalidates every slot that a lookup with the page number of `op_vaddr` and `op_asn` would hit under R1. Other slots are left as they were.
- R7: The next-to-use pointer wraps from slot ENTRIES-1 to slot 0. The insert number ENTRIES+1 after an empty array replaces slot 0.
- R8: When several slots hit, `lk_idx` and the returned fields come from the lowest-numbered hitting slot. An insert does not check for duplicates.
- R9: A lookup is combinational in the current cycle. An operation changes lookups only after the next rising clock edge, and not before it.
- R10: Operation codes 0, 5, 6 and 7 change neither the array nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation: 0 none, 1 insert, 2 flush all, 3 flush non-global, 4 flush address, 5-7 none |
| op_vaddr | input | VA_W | Virtual address for insert and flush address |
| op_asn | input | ASN_W | Address space number for insert and flush address |
| op_global | input | 1 | Global flag of the inserted entry |
| op_pfn | input | PFN_W | Physical frame number of the inserted entry |
| op_rd_en | input | MODES | Per-mode read enable mask of the inserted entry |
| op_wr_en | input | MODES | Per-mode write enable mask of the inserted entry |
| op_frd | input | 1 | Fault-on-read bit of the inserted entry |
| op_fwr | input | 1 | Fault-on-write bit of the inserted entry |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup current address space number |
| lk_hit | output | 1 | Some slot matches |
| lk_idx | output | IDX_W | Lowest matching slot index |
| lk_pfn | output | PFN_W | Frame number of the matching slot |
| lk_rd_en | output | MODES | Read enable mask of the matching slot |
| lk_wr_en | output | MODES | Write enable mask of the matching slot |
| lk_frd | output | 1 | Fault-on-read bit of the matching slot |
| lk_fwr | output | 1 | Fault-on-write bit of the matching slot |

## Verification
Lookup results are due in the same cycle as the lookup inputs. The bench drives them on a falling edge and samples one nanosecond later, with no clock edge in between. An operation is due one rising edge after it is presented. The bench drives it on a falling edge and checks its effect at the next falling edge, when it also updates its own model of slots and pointer. For inserts, a lookup made before that edge confirms that nothing changed early.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_INSERT     = 3'd1,
        OP_FLUSH_ALL  = 3'd2,
        OP_FLUSH_PROC = 3'd3,
        OP_FLUSH_ADDR = 3'd4
    } tlb_op_e;
endpackage

// File: rtl/asn_tlb_match.sv
module asn_tlb_match #(
    parameter int VPN_W = 30,
    parameter int ASN_W = 8
) (
    input  logic             slot_vld,
    input  logic             slot_glb,
    input  logic [VPN_W-1:0] slot_tag,
    input  logic [ASN_W-1:0] slot_asn,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [ASN_W-1:0] req_asn,
    output logic             hit
);
    always_comb begin
        hit = slot_vld && (slot_tag == req_vpn) && (slot_glb || (slot_asn == req_asn));
    end
endmodule

// File: rtl/asn_tlb_first.sv
module asn_tlb_first #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/asn_tlb_nlu.sv
module asn_tlb_nlu #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d = '0;
        end else if (advance) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import asn_tlb_pkg::*;
#(
    parameter int ENTRIES   = 48,
    parameter int VA_W      = 43,
    parameter int PAGE_BITS = 13,
    parameter int ASN_W     = 8,
    parameter int PFN_W     = 27,
    parameter int MODES     = 4,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [VA_W-1:0]  op_vaddr,
    input  logic [ASN_W-1:0] op_asn,
    input  logic             op_global,
    input  logic [PFN_W-1:0] op_pfn,
    input  logic [MODES-1:0] op_rd_en,
    input  logic [MODES-1:0] op_wr_en,
    input  logic             op_frd,
    input  logic             op_fwr,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_frd,
    output logic             lk_fwr
);
    typedef struct packed {
        logic             vld;
        logic             glb;
        logic [VPN_W-1:0] tag;
        logic [ASN_W-1:0] asn;
        logic [PFN_W-1:0] pfn;
        logic [MODES-1:0] rd;
        logic [MODES-1:0] wr;
        logic             frd;
        logic             fwr;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } state_t;

    state_t           st_d, st_q;
    tlb_op_e          op_e;
    logic [VPN_W-1:0] op_vpn;
    logic [IDX_W-1:0] nlu_ptr;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fa_match;
    slot_t            new_slot;
    slot_t            sel_slot;

    assign op_e   = tlb_op_e'(op);
    assign op_vpn = op_vaddr[VA_W-1:PAGE_BITS];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        asn_tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk (
            .slot_vld (st_q.slot[g].vld),
            .slot_glb (st_q.slot[g].glb),
            .slot_tag (st_q.slot[g].tag),
            .slot_asn (st_q.slot[g].asn),
            .req_vpn  (lk_vpn),
            .req_asn  (lk_asn),
            .hit      (lk_match[g])
        );
        asn_tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_fa (
            .slot_vld (st_q.slot[g].vld),
            .slot_glb (st_q.slot[g].glb),
            .slot_tag (st_q.slot[g].tag),
            .slot_asn (st_q.slot[g].asn),
            .req_vpn  (op_vpn),
            .req_asn  (op_asn),
            .hit      (fa_match[g])
        );
    end

    asn_tlb_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
        .req (lk_match),
        .any (lk_hit),
        .idx (lk_idx)
    );

    asn_tlb_nlu #(.N(ENTRIES), .IDX_W(IDX_W)) u_nlu (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (op_e == OP_FLUSH_ALL),
        .advance (op_e == OP_INSERT),
        .ptr     (nlu_ptr)
    );

    always_comb begin
        new_slot.vld = 1'b1;
        new_slot.glb = op_global;
        new_slot.tag = op_vpn;
        new_slot.asn = op_asn;
        new_slot.pfn = op_pfn;
        new_slot.rd  = op_rd_en;
        new_slot.wr  = op_wr_en;
        new_slot.frd = op_frd;
        new_slot.fwr = op_fwr;
    end

    always_comb begin
        st_d = st_q;
        case (op_e)
            OP_INSERT: begin
                st_d.slot[nlu_ptr] = new_slot;
            end
            OP_FLUSH_ALL: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    st_d.slot[i].vld = 1'b0;
                end
            end
            OP_FLUSH_PROC: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (!st_q.slot[i].glb) begin
                        st_d.slot[i].vld = 1'b0;
                    end
                end
            end
            OP_FLUSH_ADDR: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (fa_match[i]) begin
                        st_d.slot[i].vld = 1'b0;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_slot = st_q.slot[lk_idx];
    assign lk_pfn   = sel_slot.pfn;
    assign lk_rd_en = sel_slot.rd;
    assign lk_wr_en = sel_slot.wr;
    assign lk_frd   = sel_slot.frd;
    assign lk_fwr   = sel_slot.fwr;
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
    parameter int ENTRIES = 48,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 8,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op,
    input logic [VPN_W-1:0] op_vpn,
    input logic [ASN_W-1:0] op_asn,
    input logic [IDX_W-1:0] ptr,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [ASN_W-1:0] lk_asn,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic quiet_op;
    assign quiet_op = (op == 3'd0) || (op > 3'd4);

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2) |=> !lk_hit); // R4
    AST_FLUSH_ALL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2) |=> (ptr == '0)); // R4
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1 && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1)); // R2
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1 && ptr == LAST) |=> (ptr == '0)); // R7
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_op || op == 3'd3 || op == 3'd4) |=> $stable(ptr)); // R10
    AST_LOOKUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_op |=> (!($stable(lk_vpn) && $stable(lk_asn)) || ($stable(lk_hit) && $stable(lk_idx)))); // R9
    AST_FLUSH_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4 && lk_vpn == op_vpn && lk_asn == op_asn)
        |=> (!($stable(lk_vpn) && $stable(lk_asn)) || !lk_hit)); // R6
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_idx <= LAST)); // R8
endmodule

bind asn_tlb asn_tlb_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASN_W   (ASN_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .op_vpn (op_vpn),
    .op_asn (op_asn),
    .ptr    (nlu_ptr),
    .lk_vpn (lk_vpn),
    .lk_asn (lk_asn),
    .lk_hit (lk_hit),
    .lk_idx (lk_idx)
);

// File: tb/asn_tlb_test.sv
module asn_tlb_test;
    localparam int ENTRIES   = 48;
    localparam int VA_W      = 43;
    localparam int PAGE_BITS = 13;
    localparam int ASN_W     = 8;
    localparam int PFN_W     = 27;
    localparam int MODES     = 4;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       op = 3'd0;
    logic [VA_W-1:0]  op_vaddr = '0;
    logic [ASN_W-1:0] op_asn = '0;
    logic             op_global = 1'b0;
    logic [PFN_W-1:0] op_pfn = '0;
    logic [MODES-1:0] op_rd_en = '0;
    logic [MODES-1:0] op_wr_en = '0;
    logic             op_frd = 1'b0;
    logic             op_fwr = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [PFN_W-1:0] lk_pfn;
    logic [MODES-1:0] lk_rd_en;
    logic [MODES-1:0] lk_wr_en;
    logic             lk_frd;
    logic             lk_fwr;

    always #4 clk = ~clk;

    asn_tlb uut (
        .clk(clk), .rst_n(rst_n), .op(op), .op_vaddr(op_vaddr), .op_asn(op_asn),
        .op_global(op_global), .op_pfn(op_pfn), .op_rd_en(op_rd_en), .op_wr_en(op_wr_en),
        .op_frd(op_frd), .op_fwr(op_fwr), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pfn(lk_pfn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_frd(lk_frd), .lk_fwr(lk_fwr)
    );

    logic             m_vld [ENTRIES];
    logic             m_glb [ENTRIES];
    logic [VPN_W-1:0] m_tag [ENTRIES];
    logic [ASN_W-1:0] m_asn [ENTRIES];
    logic [PFN_W-1:0] m_pfn [ENTRIES];
    logic [MODES-1:0] m_rd  [ENTRIES];
    logic [MODES-1:0] m_wr  [ENTRIES];
    logic             m_frd [ENTRIES];
    logic             m_fwr [ENTRIES];
    int               m_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic bit m_match(int i, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
        return m_vld[i] && m_tag[i] == v && (m_glb[i] || m_asn[i] == a);
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic look(string req, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
        int e = -1;
        lk_vpn = v;
        lk_asn = a;
        #1;
        for (int i = ENTRIES - 1; i >= 0; i--) if (m_match(i, v, a)) e = i;
        chk(req, "hit", 64'(lk_hit), 64'(e >= 0));
        if (e >= 0) begin
            chk(req, "idx", 64'(lk_idx), 64'(e));
            chk(req, "fields", {lk_pfn, lk_rd_en, lk_wr_en, lk_frd, lk_fwr},
                {m_pfn[e], m_rd[e], m_wr[e], m_frd[e], m_fwr[e]});
        end
    endtask

    task automatic model_apply(logic [2:0] c);
        logic [VPN_W-1:0] v = op_vaddr[VA_W-1:PAGE_BITS];
        logic hit_now [ENTRIES];
        for (int i = 0; i < ENTRIES; i++) hit_now[i] = m_match(i, v, op_asn);
        case (c)
            3'd1: begin
                m_vld[m_ptr] = 1'b1; m_glb[m_ptr] = op_global; m_tag[m_ptr] = v;
                m_asn[m_ptr] = op_asn; m_pfn[m_ptr] = op_pfn; m_rd[m_ptr] = op_rd_en;
                m_wr[m_ptr] = op_wr_en; m_frd[m_ptr] = op_frd; m_fwr[m_ptr] = op_fwr;
                m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
            end
            3'd2: begin
                for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
                m_ptr = 0;
            end
            3'd3: for (int i = 0; i < ENTRIES; i++) if (!m_glb[i]) m_vld[i] = 1'b0;
            3'd4: for (int i = 0; i < ENTRIES; i++) if (hit_now[i]) m_vld[i] = 1'b0;
            default: ;
        endcase
    endtask

    // Called at a falling edge; returns at the next falling edge with op idle.
    task automatic do_op(logic [2:0] c, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic g);
        op = c;
        op_vaddr = {v, PAGE_BITS'($urandom)};
        op_asn = a;
        op_global = g;
        op_pfn = PFN_W'($urandom);
        op_rd_en = MODES'($urandom);
        op_wr_en = MODES'($urandom);
        op_frd = 1'($urandom);
        op_fwr = 1'($urandom);
        @(negedge clk);
        model_apply(c);
        op = 3'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1c0ffee);
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 0; m_glb[i] = 0; m_tag[i] = '0; m_asn[i] = '0; m_pfn[i] = '0;
            m_rd[i] = '0; m_wr[i] = '0; m_frd[i] = 0; m_fwr[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state is empty
        look("R4", 0, 0);
        look("R4", 30'h3ff, 5);

        // R9: insert not visible before the edge, visible after
        op = 3'd1; op_vaddr = {30'd10, 13'h1abc}; op_asn = 8'd1; op_global = 0;
        op_pfn = 27'h123456; op_rd_en = 4'b1010; op_wr_en = 4'b0011; op_frd = 1; op_fwr = 0;
        look("R9", 10, 1);
        @(negedge clk);
        model_apply(3'd1);
        op = 3'd0;
        look("R9", 10, 1);
        chk("R4", "first insert slot", 64'(lk_idx), 64'd0);
        // R3: fields and offset-ignoring tag
        chk("R3", "pfn", 64'(lk_pfn), 64'h123456);
        chk("R3", "masks", {lk_rd_en, lk_wr_en, lk_frd, lk_fwr}, {4'b1010, 4'b0011, 1'b1, 1'b0});
        // R1: asn mismatch misses, other vpn misses
        look("R1", 10, 2);
        chk("R1", "asn mismatch", 64'(lk_hit), 64'd0);
        look("R1", 11, 1);
        // R1: global matches any asn
        do_op(3'd1, 20, 8'd7, 1'b1);
        look("R1", 20, 8'd99);
        chk("R1", "global any asn", 64'(lk_hit), 64'd1);
        // R8: duplicate insert, lowest index wins
        do_op(3'd1, 10, 8'd1, 1'b0);
        look("R8", 10, 1);
        chk("R8", "lowest idx", 64'(lk_idx), 64'd0);
        // R10: idle codes leave state
        do_op(3'd5, 10, 1, 0);
        do_op(3'd6, 20, 7, 0);
        do_op(3'd7, 10, 1, 0);
        look("R10", 10, 1);
        look("R10", 20, 3);
        do_op(3'd1, 30, 8'd2, 1'b0);
        chk("R10", "ptr after idle codes", 64'(m_ptr), 64'd4);
        look("R2", 30, 2);
        chk("R2", "slot by pointer", 64'(lk_idx), 64'd3);
        // R6: flush address removes both duplicates only
        do_op(3'd4, 10, 8'd1, 0);
        look("R6", 10, 1);
        chk("R6", "flushed", 64'(lk_hit), 64'd0);
        look("R6", 30, 2);
        look("R6", 20, 0);
        // R6: flush address with other asn hits global entry
        do_op(3'd4, 20, 8'd55, 0);
        look("R6", 20, 7);
        chk("R6", "global flushed by addr", 64'(lk_hit), 64'd0);
        // R5: flush process
        do_op(3'd1, 40, 8'd3, 1'b1);
        do_op(3'd1, 41, 8'd3, 1'b0);
        do_op(3'd3, 0, 0, 0);
        look("R5", 40, 9);
        chk("R5", "global kept", 64'(lk_hit), 64'd1);
        look("R5", 41, 3);
        chk("R5", "non-global gone", 64'(lk_hit), 64'd0);
        look("R5", 30, 2);
        // R4 / R7: flush all then wrap
        do_op(3'd2, 0, 0, 0);
        look("R4", 40, 3);
        chk("R4", "flush all empty", 64'(lk_hit), 64'd0);
        for (int i = 0; i < ENTRIES; i++) do_op(3'd1, VPN_W'(100 + i), 8'd4, 1'b0);
        look("R7", 100, 4);
        chk("R7", "slot0 before wrap", 64'(lk_idx), 64'd0);
        do_op(3'd1, 500, 8'd4, 1'b0);
        look("R7", 100, 4);
        chk("R7", "replaced", 64'(lk_hit), 64'd0);
        look("R7", 500, 4);
        chk("R7", "wrapped to slot 0", 64'(lk_idx), 64'd0);
        look("R2", VPN_W'(100 + ENTRIES - 1), 4);

        // Random mix against the model
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom % 32;
            logic [2:0] c;
            if (r < 14) c = 3'd1;
            else if (r < 18) c = 3'd4;
            else if (r < 19) c = 3'd3;
            else if (r < 20 && ($urandom % 4) == 0) c = 3'd2;
            else c = 3'($urandom % 8 == 0 ? 5 + $urandom % 3 : 0);
            do_op(c, VPN_W'($urandom % 12), ASN_W'($urandom % 4), 1'($urandom % 4 == 0));
            look("R1", VPN_W'($urandom % 12), ASN_W'($urandom % 4));
            look("R8", VPN_W'($urandom % 12), ASN_W'($urandom % 4));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule